// File: doc/BRIEF.md
# Word-to-Byte FIFO Data Port

This block links a 32-bit register-style data port to two byte-wide queues. One queue feeds bytes toward a serial shift engine, and the other collects bytes coming back from that engine. A word write is split into four bytes and enqueued. A word read dequeues four bytes and assembles them into one word. Both directions use little-endian packing: the lowest byte lane moves first.

Each word access runs over four consecutive clock cycles, one byte per cycle, and `busy` is high while it runs. If the transmit queue fills part way through a write, the remaining bytes are discarded and the access ends with an overflow pulse. If the receive queue drains part way through a read, the access ends with an underflow pulse, and the word it returns carries zeros in the lanes that were never filled. The shift-engine side pops transmit bytes and pushes receive bytes one at a time. Each queue has its own clear input. The transmit fill level is also reported in words, rounded up.

Top module: `wordbyte_port`

## Requirements
- R1: An accepted write sends `wr_data[7:0]`, `[15:8]`, `[23:16]` and `[31:24]` into the transmit queue in that order, one byte in each of the four cycles after acceptance.
- R2: When the transmit queue holds DEPTH bytes at the turn of a write byte, that byte and every later byte of the word are discarded. `err_overflow` is high for exactly one cycle, and `busy` falls in that same cycle.
- R3: A write that completes drops `tx_empty` and raises `tx_words` by one.
- R4: An accepted read dequeues bytes into `rd_data[7:0]`, `[15:8]`, `[23:16]` and `[31:24]` in that order. `rd_valid` pulses for one cycle after the fourth byte. `rd_data` holds its value until the next read is accepted. Dequeuing from a full receive queue drops `rx_full`.
- R5: When the receive queue is empty at a read byte's turn, `err_underflow` and `rd_valid` pulse together. Lanes already filled keep their bytes and the remaining lanes read zero.
- R6: A one-cycle `tx_clr` or `rx_clr` empties that queue. In the next cycle its empty flag is 1 and its full flag is 0.
- R7: Each full flag is 1 exactly when its queue holds DEPTH bytes, and each empty flag is 1 exactly when it holds none. A push into a full receive queue and a pop from an empty transmit queue change nothing.
- R8: `busy` stays high for the four cycles after a request is accepted, or fewer if an access ends early on an error. Requests that arrive while `busy` is high are ignored. A write and a read requested in the same idle cycle start the write only.
- R9: `tx_words` equals the transmit byte count divided by four, rounded up.
- R10: After reset both queues are empty and not full, and `busy`, `rd_valid`, `err_overflow`, `err_underflow` and `tx_words` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_req | input | 1 | Request a word write into the transmit queue |
| wr_data | input | 32 | Word to write |
| rd_req | input | 1 | Request a word read from the receive queue |
| rd_data | output | 32 | Last assembled read word |
| rd_valid | output | 1 | One-cycle pulse when a read ends |
| busy | output | 1 | A word access is in progress |
| tx_clr | input | 1 | Empty the transmit queue |
| rx_clr | input | 1 | Empty the receive queue |
| tx_pop | input | 1 | Shift engine takes the head transmit byte |
| tx_byte | output | 8 | Head byte of the transmit queue |
| rx_push | input | 1 | Shift engine delivers a received byte |
| rx_byte | input | 8 | Received byte |
| tx_empty | output | 1 | Transmit queue holds no bytes |
| tx_full | output | 1 | Transmit queue holds DEPTH bytes |
| rx_empty | output | 1 | Receive queue holds no bytes |
| rx_full | output | 1 | Receive queue holds DEPTH bytes |
| tx_words | output | $clog2(DEPTH/4+1) | Transmit fill level in words, rounded up |
| err_overflow | output | 1 | One-cycle pulse when a write is cut short |
| err_underflow | output | 1 | One-cycle pulse when a read is cut short |

## Verification
Inputs are driven on the falling edge, and the rising edge after that is the acceptance edge. A complete write or read finishes at the fourth rising edge after acceptance, so `busy`, `tx_words`, `rd_valid` and `rd_data` are checked at the falling edge that follows it. An access that ends early finishes one edge after the last byte that fitted. With m bytes of room or data, its pulse is therefore sampled m+1 falling edges after the request is dropped, and the bench computes m from its own count of queued bytes. Queue flags and `tx_byte` are sampled on the falling edge after the single-cycle push, pop or clear that changed them.

// File: rtl/wbp_pkg.sv
package wbp_pkg;

    localparam int unsigned LANES     = 4;
    localparam int unsigned LANE_BITS = 8;
    localparam int unsigned WORD_BITS = LANES * LANE_BITS;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_WRITE = 2'd1,
        SEQ_READ  = 2'd2
    } seq_mode_e;

    typedef struct packed {
        seq_mode_e              mode;
        logic [1:0]             lane;
        logic [WORD_BITS-1:0]   wword;
        logic [WORD_BITS-1:0]   rword;
        logic                   ovf;
        logic                   udf;
        logic                   rvalid;
    } seq_state_t;

endpackage

// File: rtl/byte_fifo.sv
module byte_fifo #(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic [7:0]    push_data,
    input  logic          pop,
    output logic [7:0]    head,
    output logic [CW-1:0] level,
    output logic          empty,
    output logic          full
);

    typedef struct packed {
        logic [AW-1:0] wptr;
        logic [AW-1:0] rptr;
        logic [CW-1:0] cnt;
    } ptr_state_t;

    ptr_state_t st_d, st_q;
    logic [7:0] mem_q [DEPTH];
    logic       do_push;
    logic       do_pop;

    always_comb begin
        do_push = push && (st_q.cnt != CW'(DEPTH));
        do_pop  = pop && (st_q.cnt != '0);
        st_d    = st_q;
        if (do_push) begin
            st_d.wptr = (st_q.wptr == AW'(DEPTH - 1)) ? '0 : st_q.wptr + 1'b1;
        end
        if (do_pop) begin
            st_d.rptr = (st_q.rptr == AW'(DEPTH - 1)) ? '0 : st_q.rptr + 1'b1;
        end
        case ({do_push, do_pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
        if (clr) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push && !clr) begin
            mem_q[st_q.wptr] <= push_data;
        end
    end

    assign head  = mem_q[st_q.rptr];
    assign level = st_q.cnt;
    assign empty = (st_q.cnt == '0);
    assign full  = (st_q.cnt == CW'(DEPTH));

endmodule

// File: rtl/word_packer.sv
module word_packer
    import wbp_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_req,
    input  logic [WORD_BITS-1:0] wr_data,
    input  logic                 rd_req,
    input  logic                 tx_full,
    input  logic                 rx_empty,
    input  logic [7:0]           rx_head,
    output logic                 tx_push,
    output logic [7:0]           tx_push_byte,
    output logic                 rx_pop,
    output logic                 busy,
    output logic [WORD_BITS-1:0] rd_data,
    output logic                 rd_valid,
    output logic                 err_ovf,
    output logic                 err_udf
);

    seq_state_t s_d, s_q;
    logic       last_lane;

    assign last_lane = (s_q.lane == 2'(LANES - 1));

    always_comb begin
        s_d        = s_q;
        s_d.ovf    = 1'b0;
        s_d.udf    = 1'b0;
        s_d.rvalid = 1'b0;
        tx_push    = 1'b0;
        rx_pop     = 1'b0;
        case (s_q.mode)
            SEQ_IDLE: begin
                if (wr_req) begin
                    s_d.mode  = SEQ_WRITE;
                    s_d.lane  = '0;
                    s_d.wword = wr_data;
                end else if (rd_req) begin
                    s_d.mode  = SEQ_READ;
                    s_d.lane  = '0;
                    s_d.rword = '0;
                end
            end
            SEQ_WRITE: begin
                if (tx_full) begin
                    s_d.ovf  = 1'b1;
                    s_d.mode = SEQ_IDLE;
                end else begin
                    tx_push  = 1'b1;
                    s_d.lane = s_q.lane + 1'b1;
                    if (last_lane) begin
                        s_d.mode = SEQ_IDLE;
                    end
                end
            end
            SEQ_READ: begin
                if (rx_empty) begin
                    s_d.udf    = 1'b1;
                    s_d.rvalid = 1'b1;
                    s_d.mode   = SEQ_IDLE;
                end else begin
                    rx_pop = 1'b1;
                    s_d.rword[{s_q.lane, 3'b000} +: LANE_BITS] = rx_head;
                    s_d.lane = s_q.lane + 1'b1;
                    if (last_lane) begin
                        s_d.rvalid = 1'b1;
                        s_d.mode   = SEQ_IDLE;
                    end
                end
            end
            default: s_d.mode = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign tx_push_byte = s_q.wword[{s_q.lane, 3'b000} +: LANE_BITS];
    assign busy         = (s_q.mode != SEQ_IDLE);
    assign rd_data      = s_q.rword;
    assign rd_valid     = s_q.rvalid;
    assign err_ovf      = s_q.ovf;
    assign err_udf      = s_q.udf;

endmodule

// File: rtl/wordbyte_port.sv
module wordbyte_port
    import wbp_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned CW   = $clog2(DEPTH + 1),
    localparam int unsigned WW   = $clog2(DEPTH / LANES + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_req,
    input  logic [WORD_BITS-1:0] wr_data,
    input  logic                 rd_req,
    output logic [WORD_BITS-1:0] rd_data,
    output logic                 rd_valid,
    output logic                 busy,
    input  logic                 tx_clr,
    input  logic                 rx_clr,
    input  logic                 tx_pop,
    output logic [7:0]           tx_byte,
    input  logic                 rx_push,
    input  logic [7:0]           rx_byte,
    output logic                 tx_empty,
    output logic                 tx_full,
    output logic                 rx_empty,
    output logic                 rx_full,
    output logic [WW-1:0]        tx_words,
    output logic                 err_overflow,
    output logic                 err_underflow
);

    logic          seq_tx_push;
    logic [7:0]    seq_tx_byte;
    logic          seq_rx_pop;
    logic [7:0]    rx_head;
    logic [CW-1:0] tx_level;
    logic [CW-1:0] rx_level;
    logic [CW:0]   tx_round;

    byte_fifo #(.DEPTH(DEPTH)) u_txq (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (tx_clr),
        .push      (seq_tx_push),
        .push_data (seq_tx_byte),
        .pop       (tx_pop),
        .head      (tx_byte),
        .level     (tx_level),
        .empty     (tx_empty),
        .full      (tx_full)
    );

    byte_fifo #(.DEPTH(DEPTH)) u_rxq (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (rx_clr),
        .push      (rx_push),
        .push_data (rx_byte),
        .pop       (seq_rx_pop),
        .head      (rx_head),
        .level     (rx_level),
        .empty     (rx_empty),
        .full      (rx_full)
    );

    word_packer u_pack (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_req       (wr_req),
        .wr_data      (wr_data),
        .rd_req       (rd_req),
        .tx_full      (tx_full),
        .rx_empty     (rx_empty),
        .rx_head      (rx_head),
        .tx_push      (seq_tx_push),
        .tx_push_byte (seq_tx_byte),
        .rx_pop       (seq_rx_pop),
        .busy         (busy),
        .rd_data      (rd_data),
        .rd_valid     (rd_valid),
        .err_ovf      (err_overflow),
        .err_udf      (err_underflow)
    );

    assign tx_round = {1'b0, tx_level} + (CW + 1)'(LANES - 1);
    assign tx_words = WW'(tx_round >> 2);

    logic unused_rx_level;
    assign unused_rx_level = ^rx_level;

endmodule

// File: rtl/wbp_checker.sv
module wbp_checker #(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned WW   = $clog2(DEPTH / 4 + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_req,
    input logic          rd_req,
    input logic          busy,
    input logic          rd_valid,
    input logic          tx_full,
    input logic          rx_empty,
    input logic [WW-1:0] tx_words,
    input logic          err_overflow,
    input logic          err_underflow
);

    AST_OVF_ON_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        err_overflow |-> $past(tx_full)) else $error("overflow without full queue"); // R2

    AST_OVF_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        err_overflow |=> !err_overflow) else $error("overflow pulse too long"); // R2

    AST_UDF_ON_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        err_underflow |-> ($past(rx_empty) && rd_valid)) else $error("underflow mismatch"); // R5

    AST_RVALID_ENDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (!busy && $past(busy))) else $error("rd_valid outside read end"); // R4

    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && (wr_req || rd_req)) |=> busy) else $error("request not accepted"); // R8

    AST_WORDS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        tx_words <= WW'(DEPTH / 4)) else $error("tx_words out of range"); // R9

endmodule

bind wordbyte_port wbp_checker #(.DEPTH(DEPTH)) u_wbp_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_req        (wr_req),
    .rd_req        (rd_req),
    .busy          (busy),
    .rd_valid      (rd_valid),
    .tx_full       (tx_full),
    .rx_empty      (rx_empty),
    .tx_words      (tx_words),
    .err_overflow  (err_overflow),
    .err_underflow (err_underflow)
);

// File: tb/sim_wordbyte_port.sv
`timescale 1ns/1ps
module sim_wordbyte_port;

    localparam int DEPTH = 16;
    localparam int WW    = $clog2(DEPTH / 4 + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_req = 1'b0;
    logic [31:0]   wr_data = '0;
    logic          rd_req = 1'b0;
    logic [31:0]   rd_data;
    logic          rd_valid;
    logic          busy;
    logic          tx_clr = 1'b0;
    logic          rx_clr = 1'b0;
    logic          tx_pop = 1'b0;
    logic [7:0]    tx_byte;
    logic          rx_push = 1'b0;
    logic [7:0]    rx_byte = '0;
    logic          tx_empty, tx_full, rx_empty, rx_full;
    logic [WW-1:0] tx_words;
    logic          err_overflow, err_underflow;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    wordbyte_port #(.DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_data(wr_data),
        .rd_req(rd_req), .rd_data(rd_data), .rd_valid(rd_valid), .busy(busy),
        .tx_clr(tx_clr), .rx_clr(rx_clr), .tx_pop(tx_pop), .tx_byte(tx_byte),
        .rx_push(rx_push), .rx_byte(rx_byte), .tx_empty(tx_empty),
        .tx_full(tx_full), .rx_empty(rx_empty), .rx_full(rx_full),
        .tx_words(tx_words), .err_overflow(err_overflow),
        .err_underflow(err_underflow)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic push_rx(input logic [7:0] b);
        @(negedge clk);
        rx_push = 1'b1;
        rx_byte = b;
        @(negedge clk);
        rx_push = 1'b0;
    endtask

    task automatic pop_tx(output logic [7:0] b);
        @(negedge clk);
        b = tx_byte;
        tx_pop = 1'b1;
        @(negedge clk);
        tx_pop = 1'b0;
    endtask

    // k: falling edges after the request is dropped at which the access ends
    task automatic do_write(input logic [31:0] d, input int k, input logic ovf_exp, input string req);
        @(negedge clk);
        wr_req  = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_req = 1'b0;
        check({req, " busy after accept"}, 32'(busy), 32'd1);
        repeat (k) @(negedge clk);
        check({req, " busy at end"}, 32'(busy), 32'd0);
        check({req, " err_overflow"}, 32'(err_overflow), 32'(ovf_exp));
    endtask

    task automatic do_read(input logic [31:0] exp, input int k, input logic udf_exp, input string req);
        @(negedge clk);
        rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
        repeat (k) @(negedge clk);
        check({req, " rd_valid"}, 32'(rd_valid), 32'd1);
        check({req, " rd_data"}, rd_data, exp);
        check({req, " err_underflow"}, 32'(err_underflow), 32'(udf_exp));
        @(negedge clk);
        check({req, " rd_valid one cycle"}, 32'(rd_valid), 32'd0);
        check({req, " rd_data held"}, rd_data, exp);
    endtask

    task automatic t_reset;
        check("R10 tx_empty", 32'(tx_empty), 32'd1);
        check("R10 tx_full", 32'(tx_full), 32'd0);
        check("R10 rx_empty", 32'(rx_empty), 32'd1);
        check("R10 rx_full", 32'(rx_full), 32'd0);
        check("R10 busy", 32'(busy), 32'd0);
        check("R10 tx_words", 32'(tx_words), 32'd0);
        check("R10 errs", 32'({err_overflow, err_underflow, rd_valid}), 32'd0);
    endtask

    task automatic t_write_order;
        logic [7:0] b;
        @(negedge clk);
        wr_req  = 1'b1;
        wr_data = 32'h4433_2211;
        @(negedge clk);
        wr_data = 32'hDEAD_BEEF;          // R8 request while busy: ignored
        check("R8 busy after accept", 32'(busy), 32'd1);
        @(negedge clk);
        wr_req = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R8 busy in fourth cycle", 32'(busy), 32'd1);
        @(negedge clk);
        check("R8 busy drops", 32'(busy), 32'd0);
        check("R3 tx_words", 32'(tx_words), 32'd1);
        check("R3 tx_empty", 32'(tx_empty), 32'd0);
        pop_tx(b); check("R1 lane0", 32'(b), 32'h11);
        check("R9 words after one pop", 32'(tx_words), 32'd1);
        pop_tx(b); check("R1 lane1", 32'(b), 32'h22);
        pop_tx(b); check("R1 lane2", 32'(b), 32'h33);
        pop_tx(b); check("R1 lane3", 32'(b), 32'h44);
        check("R7 tx_empty after drain", 32'(tx_empty), 32'd1);
        check("R8 busy word ignored R9", 32'(tx_words), 32'd0);
    endtask

    task automatic t_overflow;
        logic [7:0] b;
        for (int w = 0; w < 4; w++) begin
            do_write({8'(4*w+3), 8'(4*w+2), 8'(4*w+1), 8'(4*w)}, 4, 1'b0, "R3 fill");
        end
        check("R7 tx_full", 32'(tx_full), 32'd1);
        check("R9 words full", 32'(tx_words), 32'd4);
        do_write(32'h9999_9999, 1, 1'b1, "R2 no room");
        @(negedge clk);
        check("R2 pulse one cycle", 32'(err_overflow), 32'd0);
        pop_tx(b); check("R2 head kept", 32'(b), 32'h00);
        pop_tx(b); check("R2 second byte", 32'(b), 32'h01);
        check("R9 words of 14 bytes", 32'(tx_words), 32'd4);
        do_write(32'hAABB_CCDD, 3, 1'b1, "R2 partial");
        for (int i = 2; i < 16; i++) begin
            pop_tx(b); check("R2 old byte", 32'(b), 32'(i));
        end
        pop_tx(b); check("R2 partial lane0", 32'(b), 32'hDD);
        pop_tx(b); check("R2 partial lane1", 32'(b), 32'hCC);
        check("R2 rest dropped", 32'(tx_empty), 32'd1);
        pop_tx(b);                         // R7 pop while empty ignored
        do_write(32'h0000_0057, 4, 1'b0, "R7 after empty pop");
        check("R7 empty pop words", 32'(tx_words), 32'd1);
        pop_tx(b); check("R7 empty pop head", 32'(b), 32'h57);
    endtask

    task automatic t_tx_clr;
        do_write(32'h1234_5678, 4, 1'b0, "R6 setup");
        @(negedge clk); tx_clr = 1'b1;
        @(negedge clk); tx_clr = 1'b0;
        check("R6 tx_empty", 32'(tx_empty), 32'd1);
        check("R6 tx_full", 32'(tx_full), 32'd0);
        check("R6 tx_words", 32'(tx_words), 32'd0);
    endtask

    task automatic t_read;
        push_rx(8'hA1); push_rx(8'hA2); push_rx(8'hA3); push_rx(8'hA4);
        push_rx(8'hB1); push_rx(8'hB2);
        do_read(32'hA4A3_A2A1, 4, 1'b0, "R4 full word");
        do_read(32'h0000_B2B1, 3, 1'b1, "R5 partial word");
        check("R5 rx_empty", 32'(rx_empty), 32'd1);
    endtask

    task automatic t_rx_full;
        for (int i = 0; i < 16; i++) push_rx(8'(8'h10 + i));
        push_rx(8'hEE);                    // R7 dropped
        check("R7 rx_full", 32'(rx_full), 32'd1);
        do_read(32'h1312_1110, 4, 1'b0, "R4 from full");
        check("R4 rx_full cleared", 32'(rx_full), 32'd0);
        for (int w = 1; w < 4; w++) begin
            do_read({8'(8'h13+4*w), 8'(8'h12+4*w), 8'(8'h11+4*w), 8'(8'h10+4*w)}, 4, 1'b0, "R7 no extra byte");
        end
        check("R7 rx_empty", 32'(rx_empty), 32'd1);
        push_rx(8'h77);
        @(negedge clk); rx_clr = 1'b1;
        @(negedge clk); rx_clr = 1'b0;
        check("R6 rx_empty", 32'(rx_empty), 32'd1);
        check("R6 rx_full", 32'(rx_full), 32'd0);
        do_read(32'h0000_0000, 1, 1'b1, "R5 empty read");
    endtask

    task automatic t_both;
        logic [7:0] b;
        push_rx(8'hC1); push_rx(8'hC2); push_rx(8'hC3); push_rx(8'hC4);
        @(negedge clk);
        wr_req = 1'b1; rd_req = 1'b1; wr_data = 32'h0504_0302;
        @(negedge clk);
        wr_req = 1'b0; rd_req = 1'b0;
        repeat (4) @(negedge clk);
        check("R8 write wins rd_valid", 32'(rd_valid), 32'd0);
        check("R8 write wins tx_words", 32'(tx_words), 32'd1);
        check("R8 write wins rx kept", 32'(rx_empty), 32'd0);
        do_read(32'hC4C3_C2C1, 4, 1'b0, "R8 read after");
        pop_tx(b); check("R8 written head", 32'(b), 32'h02);
    endtask

    initial begin
        repeat (20000) @(negedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write_order();
        t_overflow();
        t_tx_clr();
        t_read();
        t_rx_full();
        t_both();
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule